// File: doc/BRIEF.md
# Bit-Serial Corner-Turn Buffer

This block sits at the front of a bank of distributed-arithmetic units. It takes a stream of 16-bit samples, one word per clock, and groups them into blocks of eight. Each complete block is then presented as eight bit-serial lanes, all at once. Every output beat carries a 2-bit slice of every sample of the block, with the least significant pair first. Eight beats therefore drain one block, so each downstream unit receives its own sample two bits per clock.

The storage is sixteen 16-bit words, split into two banks of eight. One bank fills while the other drains, so a steady stream of one sample per clock passes through without stalls. Both sides are valid/ready streams:
- The input side asserts `in_ready` while the bank selected for writing is empty. A word is taken on any clock where `in_valid` and `in_ready` are both high.
- The output side holds its beat until `out_ready` is high. While `out_valid` is high and `out_ready` is low, the beat does not change.
- If the reader stalls, the idle bank fills. After that, `in_ready` falls until the reader frees a bank.

The sample count, the word width and the bits per beat are parameters.

Top module: `bitslice_turn_buf`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` and `out_first` are 0 and `in_ready` is 1.
- R2: A word is accepted exactly on a clock where `in_valid` and `in_ready` are both high. The k-th accepted word of a block (k = 0..7, counted from the first word after the previous block's eighth) is sample k of that block.
- R3: On every output beat, bits [2i+1:2i] of `out_bits` equal bits [2s+1:2s] of sample i of the current block, where s is `out_idx`.
- R4: `out_idx` is 0 on the first beat of each block and rises by one on each beat taken (`out_valid` and `out_ready` both high). A block stops being presented only after its beat with `out_idx` = 7 is taken.
- R5: `out_first` is high exactly on beats where `out_valid` is high and `out_idx` is 0.
- R6: With `in_valid` and `out_ready` held high, the first `out_valid` appears 8 cycles after the first word is accepted. `in_ready` never falls, so one sample per clock is sustained.
- R7: Cycles with `in_valid` low leave the write position unchanged. A block is not presented until its eighth word has been accepted, however long the gaps between words.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bits` and `out_idx` hold their values on the next cycle.
- R9: With `out_ready` low, at most 16 words are accepted, after which `in_ready` is 0. Words offered while `in_ready` is 0 are ignored and never appear at the output.
- R10: Blocks are presented in the order in which they were filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Buffer can take a word this cycle |
| in_data | input | 16 | Input sample, bit-parallel |
| out_valid | output | 1 | A beat of a complete block is presented |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| out_bits | output | 16 | Slice s of sample i at bits [2i+1:2i] |
| out_idx | output | 3 | Slice number s of the current beat |
| out_first | output | 1 | High on the first beat of a block |

## Verification
A wrong write pointer or bank select does not show at once. It shows as a wrong 2-bit field in the very first beat of the block it damaged, eight cycles after that block's first word. It can also show as samples coming out in a rotated lane order.

A wrong occupancy flag shows within one cycle:
- `in_ready` falls during a steady stream, or
- `out_valid` rises before the eighth word.

A lost or duplicated flag shows as a block presented twice, or a block skipped. Either one breaks the order of the output stream. For this reason the sweeps compare every beat against a queue of the accepted words, across many combinations of input gaps and output stalls.

// File: rtl/bstb_pkg.sv
package bstb_pkg;

  // Default geometry of the corner turn.
  localparam int unsigned DEF_NSAMP = 8;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_BEAT_BITS = 2;

  // Which of the two banks a pointer refers to.
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_sel_e;

  function automatic bank_sel_e other_bank(input bank_sel_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/bstb_bank_store.sv
module bstb_bank_store
  import bstb_pkg::*;
#(
  parameter int unsigned NSAMP = DEF_NSAMP,
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned BEAT_BITS = DEF_BEAT_BITS,
  localparam int unsigned SLICES = WORD_W / BEAT_BITS,
  localparam int unsigned PTR_W = $clog2(NSAMP),
  localparam int unsigned IDX_W = $clog2(SLICES)
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  bank_sel_e                  wr_bank,
  input  logic [PTR_W-1:0]           wr_ptr,
  input  logic [WORD_W-1:0]          wr_data,
  input  bank_sel_e                  rd_bank,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [NSAMP*BEAT_BITS-1:0] rd_lanes
);

  logic [WORD_W-1:0] mem_q [2][NSAMP];

  // Write side: one word lands in the selected bank and slot.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar w = 0; w < NSAMP; w++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_bank == bank_sel_e'(b)) && (wr_ptr == PTR_W'(w));
      always_ff @(posedge clk) begin
        if (hit) begin
          mem_q[b][w] <= wr_data;
        end
      end
    end
  end

  // Read side: the same slice of every word of the draining bank.
  for (genvar i = 0; i < NSAMP; i++) begin : g_lane
    logic [WORD_W-1:0] word;
    assign word = (rd_bank == BANK_B) ? mem_q[1][i] : mem_q[0][i];
    assign rd_lanes[i*BEAT_BITS +: BEAT_BITS] =
      word[rd_idx*BEAT_BITS +: BEAT_BITS];
  end

endmodule

// File: rtl/bstb_occupancy.sv
module bstb_occupancy
  import bstb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fill_done,
  input  bank_sel_e  fill_bank,
  input  logic       drain_done,
  input  bank_sel_e  drain_bank,
  output logic [1:0] bank_full
);

  // A bank is set full by the writer and cleared by the reader. The writer
  // only touches an empty bank and the reader only a full one, so the two
  // never target the same bank at the same edge.
  for (genvar b = 0; b < 2; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_full[b] <= 1'b0;
      end else if (fill_done && (fill_bank == bank_sel_e'(b))) begin
        bank_full[b] <= 1'b1;
      end else if (drain_done && (drain_bank == bank_sel_e'(b))) begin
        bank_full[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bstb_wr_seq.sv
module bstb_wr_seq
  import bstb_pkg::*;
#(
  parameter int unsigned NSAMP = DEF_NSAMP,
  localparam int unsigned PTR_W = $clog2(NSAMP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       bank_full,
  output logic             in_ready,
  output logic             wr_en,
  output bank_sel_e        wr_bank,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             fill_done
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NSAMP - 1);

  assign in_ready  = !bank_full[wr_bank];
  assign wr_en     = in_valid && in_ready;
  assign fill_done = wr_en && (wr_ptr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wr_bank <= BANK_A;
    end else if (wr_en) begin
      if (wr_ptr == LAST) begin
        wr_ptr  <= '0;
        wr_bank <= other_bank(wr_bank);
      end else begin
        wr_ptr <= wr_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bstb_rd_seq.sv
module bstb_rd_seq
  import bstb_pkg::*;
#(
  parameter int unsigned SLICES = 8,
  localparam int unsigned IDX_W = $clog2(SLICES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_ready,
  input  logic [1:0]       bank_full,
  output logic             out_valid,
  output logic             out_first,
  output bank_sel_e        rd_bank,
  output logic [IDX_W-1:0] rd_idx,
  output logic             drain_done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLICES - 1);

  logic step;

  assign out_valid  = bank_full[rd_bank];
  assign out_first  = out_valid && (rd_idx == '0);
  assign step       = out_valid && out_ready;
  assign drain_done = step && (rd_idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      rd_bank <= BANK_A;
    end else if (step) begin
      if (rd_idx == LAST) begin
        rd_idx  <= '0;
        rd_bank <= other_bank(rd_bank);
      end else begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bitslice_turn_buf.sv
module bitslice_turn_buf
  import bstb_pkg::*;
#(
  parameter int unsigned NSAMP = DEF_NSAMP,
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned BEAT_BITS = DEF_BEAT_BITS,
  localparam int unsigned SLICES = WORD_W / BEAT_BITS,
  localparam int unsigned PTR_W = $clog2(NSAMP),
  localparam int unsigned IDX_W = $clog2(SLICES),
  localparam int unsigned LANES_W = NSAMP * BEAT_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LANES_W-1:0] out_bits,
  output logic [IDX_W-1:0]   out_idx,
  output logic               out_first
);

  logic [1:0]       bank_full;
  logic             wr_en;
  bank_sel_e        wr_bank;
  logic [PTR_W-1:0] wr_ptr;
  logic             fill_done;
  bank_sel_e        rd_bank;
  logic             drain_done;

  bstb_wr_seq #(.NSAMP(NSAMP)) wr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bank_full (bank_full),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_bank   (wr_bank),
    .wr_ptr    (wr_ptr),
    .fill_done (fill_done)
  );

  bstb_rd_seq #(.SLICES(SLICES)) rd_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_ready  (out_ready),
    .bank_full  (bank_full),
    .out_valid  (out_valid),
    .out_first  (out_first),
    .rd_bank    (rd_bank),
    .rd_idx     (out_idx),
    .drain_done (drain_done)
  );

  bstb_occupancy occ_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_done  (fill_done),
    .fill_bank  (wr_bank),
    .drain_done (drain_done),
    .drain_bank (rd_bank),
    .bank_full  (bank_full)
  );

  bstb_bank_store #(
    .NSAMP     (NSAMP),
    .WORD_W    (WORD_W),
    .BEAT_BITS (BEAT_BITS)
  ) store_i (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_ptr   (wr_ptr),
    .wr_data  (in_data),
    .rd_bank  (rd_bank),
    .rd_idx   (out_idx),
    .rd_lanes (out_bits)
  );

endmodule

// File: rtl/bstb_checker.sv
module bstb_checker #(
  parameter int unsigned LANES_W = 16,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned SLICES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LANES_W-1:0] out_bits,
  input logic [IDX_W-1:0]   out_idx,
  input logic               out_first
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLICES - 1);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_first && in_ready));

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=>
      (out_idx == (($past(out_idx) == LAST) ? '0 : IDX_W'($past(out_idx) + 1'b1))));

  assert_drain_whole_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> ($past(out_ready) && ($past(out_idx) == LAST)));

  assert_first_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> (out_valid && (out_idx == '0)));

  assert_hold_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_bits) && $stable(out_idx)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

endmodule

bind bitslice_turn_buf bstb_checker #(
  .LANES_W (LANES_W),
  .IDX_W   (IDX_W),
  .SLICES  (SLICES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bits  (out_bits),
  .out_idx   (out_idx),
  .out_first (out_first)
);

// File: tb/bitslice_turn_buf_tb_top.sv
module bitslice_turn_buf_tb_top;

  localparam int NSAMP = 8;
  localparam int WORD_W = 16;
  localparam int BB = 2;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [WORD_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [NSAMP*BB-1:0] out_bits;
  logic [2:0] out_idx;
  logic out_first;

  always #5 clk = ~clk;

  bitslice_turn_buf dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bits  (out_bits),
    .out_idx   (out_idx),
    .out_first (out_first)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit last_acc;
  logic [WORD_W-1:0] q[$];
  int beat = 0;
  int first_acc = -1;
  int first_ov = -1;
  bit hold_pend = 1'b0;
  logic [NSAMP*BB-1:0] hold_bits;
  logic [2:0] hold_idx;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= LIMIT && !finished) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, LIMIT);
      finish_run();
    end
  end

  // Monitor: reference model built from the accepted words only.
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(out_valid && out_bits == hold_bits && out_idx == hold_idx,
            "R8 held beat", {out_idx, out_bits}, {hold_idx, hold_bits});
        hold_pend = 1'b0;
      end
      if (in_valid && in_ready) begin
        q.push_back(in_data);
        if (first_acc < 0) first_acc = cyc;
      end
      if (out_valid && first_ov < 0) first_ov = cyc;
      if (out_valid) begin
        logic [NSAMP*BB-1:0] exp_bits;
        chk(q.size() >= NSAMP, "R7 block complete", q.size(), NSAMP);
        for (int i = 0; i < NSAMP; i++) begin
          exp_bits[i*BB +: BB] = (q.size() > i) ? q[i][beat*BB +: BB] : 2'b00;
        end
        chk(out_bits == exp_bits, "R3 R10 lanes", out_bits, exp_bits);
        chk(out_idx == 3'(beat), "R4 slice index", out_idx, beat);
        chk(out_first == (beat == 0), "R5 first flag", out_first, beat == 0);
        if (out_ready) begin
          if (beat == NSAMP - 1) begin
            beat = 0;
            for (int i = 0; i < NSAMP; i++) void'(q.pop_front());
          end else begin
            beat++;
          end
        end else begin
          hold_pend = 1'b1;
          hold_bits = out_bits;
          hold_idx = out_idx;
        end
      end else begin
        chk(!out_first, "R5 first idle", out_first, 0);
      end
    end
  end

  task automatic drive_cycle(input bit iv, input bit ordy);
    in_valid = iv;
    out_ready = ordy;
    in_data = 16'(cyc * 40503 + 16'h1F3C);
    last_acc = iv && in_ready;
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (q.size() != 0 || out_valid) drive_cycle(1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid && !out_first && in_ready, "R1 in reset",
        {out_valid, out_first, in_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_first && in_ready, "R1 after reset",
        {out_valid, out_first, in_ready}, 3'b001);
    @(posedge clk);
    #1;

    // Steady stream: latency and sustained rate.
    begin
      int stalls = 0;
      for (int k = 0; k < 40; k++) begin
        if (!in_ready) stalls++;
        drive_cycle(1'b1, 1'b1);
      end
      chk(stalls == 0, "R6 no input stall", stalls, 0);
      chk(first_ov - first_acc == 8, "R6 latency", first_ov - first_acc, 8);
    end
    drain();

    // Gaps on the input side.
    for (int k = 0; k < 14; k++) drive_cycle(k % 2 == 0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      drive_cycle(1'b0, 1'b1);
      chk(!out_valid, "R7 seven words only", out_valid, 0);
    end
    drive_cycle(1'b1, 1'b1);
    chk(out_valid && out_first, "R7 eighth word releases", {out_valid, out_first}, 2'b11);
    drain();

    // Output stalled: both banks fill, then input is refused.
    begin
      int acc = 0;
      for (int k = 0; k < 22; k++) begin
        drive_cycle(1'b1, 1'b0);
        if (last_acc) acc++;
      end
      chk(acc == 16, "R9 accepted count", acc, 16);
      chk(!in_ready, "R9 ready low", in_ready, 0);
      chk(out_valid && out_idx == 0, "R8 stalled beat", {out_valid, out_idx}, 4'b1000);
      chk(q.size() == 16, "R2 R9 queued words", q.size(), 16);
    end
    drain();
    chk(in_ready && !out_valid, "R9 recovered", {in_ready, out_valid}, 2'b10);

    // Sweep of input gap periods against output stall periods.
    for (int gp = 1; gp <= 4; gp++) begin
      for (int rp = 1; rp <= 4; rp++) begin
        for (int c = 0; c < 30; c++) begin
          drive_cycle((c % gp) == 0, (rp == 1) || ((c % rp) != 1));
        end
      end
    end
    while (q.size() % NSAMP != 0) drive_cycle(1'b1, 1'b1);
    drain();
    chk(!out_valid && q.size() == 0, "R10 all blocks out", q.size(), 0);

    finish_run();
  end

endmodule